// File: doc/BRIEF.md
# 32-bit SEC-DED Hamming Codec

This block protects a 32-bit data word with a 7-bit check word using an odd-column-weight Hamming code. The write side takes a data word and returns the seven check bits to be stored beside it. The read side takes a stored 39-bit word (data plus check) and returns a 7-bit syndrome, two active-low error flags and a data word in which any single flipped data bit has been put right.

Every data column of the parity matrix has weight 3 or 5, and every check bit covers exactly sixteen data bits. Because of this, a single data error always disturbs an odd number of syndrome bits, and any pair of errors disturbs an even number. Two check bits use inverted parity. As a result, a word read back as all zeros, or as all ones, is never taken for a clean word. Both paths are combinational and end in one output register stage, so each result appears one clock after its inputs.

Top module: `secded_codec`

## Requirements
- R1: Each check bit is the parity of exactly 16 of the 32 data bits. Each data bit feeds 3 or 5 check bits.
- R2: The 32 data columns are pairwise distinct, and each has a weight of 3 or 5. Bit r of column i is check bit r's response to data bit i alone, after the inversion mask is removed.
- R3: A word that the encoder produced, read back unchanged, yields syndrome 0. Both flags stay high, and the data comes out unchanged.
- R4: When exactly one data bit i is flipped, the block drives err_n_o low and merr_n_o high. The syndrome equals column i, and bit i is inverted back on fix_data_o.
- R5: When exactly one check bit j is flipped, the block drives err_n_o low and merr_n_o high. The syndrome is one-hot at bit j, and the data passes through unchanged.
- R6: Any two flipped bits among the 39 give a nonzero syndrome of even weight and drive both flags low.
- R7: An odd-weight syndrome that matches no column (for example 7'h7F) drives both flags low and leaves the data uncorrected.
- R8: A 39-bit word of all zeros drives both flags low.
- R9: A 39-bit word of all ones drives err_n_o low.
- R10: syndrome_o bit r equals received check bit r XOR the check bit recomputed from the received data, for r = 0 to 6.
- R11: Every output is registered, and each result appears on the first rising edge after its inputs are applied. In reset, both flags are high and every other output is zero.
- R12: The inversion mask is 7'h03, so encoding the all-zero data word gives check bits 7'h03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 32 | Data word to encode |
| enc_check_o | output | 7 | Check word for enc_data_i |
| rd_data_i | input | 32 | Data part of the stored word |
| rd_check_i | input | 7 | Check part of the stored word |
| fix_data_o | output | 32 | Corrected data word |
| syndrome_o | output | 7 | Received check XOR recomputed check |
| err_n_o | output | 1 | Low when any error is seen |
| merr_n_o | output | 1 | Low when the error is not correctable |

## Verification
A wrong matrix entry shows one cycle later in one of two ways: as a column of the wrong weight or a duplicate, or as a row sum other than sixteen when unit vectors are encoded. A fault in the column compare shows on the very next edge. The faulty bit is either left uncorrected, or a bit that was never flipped gets inverted, and the flags disagree with the syndrome's weight. Mismatched inversion masks between the two encoders give a nonzero syndrome on clean words at once.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;

    // check bits whose parity is inverted so that all-zero memory is illegal
    localparam logic [CHK_W-1:0] CHK_INVERT = 7'h03;

    typedef struct packed {
        logic [CHK_W-1:0]  enc_check;
        logic [DATA_W-1:0] fix_data;
        logic [CHK_W-1:0]  syndrome;
        logic              err_n;
        logic              merr_n;
    } codec_out_t;

    // cyclic rotation of a check-space mask by k places
    function automatic logic [CHK_W-1:0] rot_mask(input logic [CHK_W-1:0] m, input int k);
        logic [CHK_W-1:0] r;
        r = '0;
        for (int i = 0; i < CHK_W; i++) begin
            r[(i + k) % CHK_W] = m[i];
        end
        return r;
    endfunction

    // column of the parity matrix for data bit j:
    // three weight-3 rotation classes, one weight-5 class, four balancing columns
    function automatic logic [CHK_W-1:0] data_column(input int j);
        if (j < 7)       return rot_mask(7'h23, j);
        else if (j < 14) return rot_mask(7'h13, j - 7);
        else if (j < 21) return rot_mask(7'h15, j - 14);
        else if (j < 28) return rot_mask(7'h76, j - 21);
        else begin
            case (j)
                28:      return 7'h61;
                29:      return 7'h62;
                30:      return 7'h1C;
                default: return 7'h1F;
            endcase
        end
    endfunction

    // data bits covered by check bit r
    function automatic logic [DATA_W-1:0] row_mask(input int r);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0]  c;
        m = '0;
        for (int j = 0; j < DATA_W; j++) begin
            c    = data_column(j);
            m[j] = c[r];
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc
    import secded_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] check_o
);
    for (genvar r = 0; r < CW; r++) begin : g_row
        localparam logic [DW-1:0] ROW = row_mask(r);
        assign check_o[r] = (^(data_i & ROW)) ^ CHK_INVERT[r];
    end
endmodule

// File: rtl/secded_dec.sv
`timescale 1ns/1ps
module secded_dec
    import secded_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [CW-1:0] syndrome_i,
    output logic [DW-1:0] flip_o,
    output logic          err_n_o,
    output logic          merr_n_o
);
    logic any_err;
    logic data_hit;
    logic check_hit;

    for (genvar j = 0; j < DW; j++) begin : g_col
        localparam logic [CW-1:0] COL = data_column(j);
        assign flip_o[j] = (syndrome_i == COL);
    end

    always_comb begin
        any_err   = |syndrome_i;
        data_hit  = |flip_o;
        check_hit = $onehot(syndrome_i);
        err_n_o   = !any_err;
        merr_n_o  = !(any_err && !data_hit && !check_hit);
    end
endmodule

// File: rtl/secded_fix.sv
`timescale 1ns/1ps
module secded_fix
    import secded_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] flip_i,
    output logic [DW-1:0] data_o
);
    assign data_o = data_i ^ flip_i;
endmodule

// File: rtl/secded_codec.sv
`timescale 1ns/1ps
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_check_o,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [CHK_W-1:0]  rd_check_i,
    output logic [DATA_W-1:0] fix_data_o,
    output logic [CHK_W-1:0]  syndrome_o,
    output logic              err_n_o,
    output logic              merr_n_o
);
    logic [CHK_W-1:0]  wr_check;
    logic [CHK_W-1:0]  rd_recalc;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip;
    logic [DATA_W-1:0] fixed;
    logic              err_n;
    logic              merr_n;

    codec_out_t out_d, out_q;

    secded_enc u_wr_enc (.data_i(enc_data_i), .check_o(wr_check));
    secded_enc u_rd_enc (.data_i(rd_data_i),  .check_o(rd_recalc));

    assign syn = rd_check_i ^ rd_recalc;

    secded_dec u_dec (
        .syndrome_i(syn),
        .flip_o    (flip),
        .err_n_o   (err_n),
        .merr_n_o  (merr_n)
    );

    secded_fix u_fix (.data_i(rd_data_i), .flip_i(flip), .data_o(fixed));

    always_comb begin
        out_d           = out_q;
        out_d.enc_check = wr_check;
        out_d.syndrome  = syn;
        out_d.err_n     = err_n;
        out_d.merr_n    = merr_n;
        out_d.fix_data  = fixed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{enc_check: '0, fix_data: '0, syndrome: '0, err_n: 1'b1, merr_n: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign enc_check_o = out_q.enc_check;
    assign fix_data_o  = out_q.fix_data;
    assign syndrome_o  = out_q.syndrome;
    assign err_n_o     = out_q.err_n;
    assign merr_n_o    = out_q.merr_n;
endmodule

// File: rtl/secded_codec_chk.sv
`timescale 1ns/1ps
module secded_codec_chk
    import secded_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rd_data_i,
    input logic [CHK_W-1:0]  rd_check_i,
    input logic [DATA_W-1:0] fix_data_o,
    input logic [CHK_W-1:0]  syndrome_o,
    input logic              err_n_o,
    input logic              merr_n_o
);
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    assert_clean_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_n_o |-> (syndrome_o == '0 && merr_n_o));

    assert_clean_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && err_n_o) |-> (fix_data_o == $past(rd_data_i)));

    assert_check_bit_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $countones(syndrome_o) == 1) |->
            (!err_n_o && merr_n_o && fix_data_o == $past(rd_data_i)));

    assert_flag_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !merr_n_o |-> !err_n_o);

    assert_even_syndrome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (syndrome_o != '0 && ($countones(syndrome_o) % 2) == 0) |-> !merr_n_o);

    assert_syndrome_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(rd_data_i) == '0) |->
            (syndrome_o == ($past(rd_check_i) ^ CHK_INVERT)));
endmodule

bind secded_codec secded_codec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_data_i (rd_data_i),
    .rd_check_i(rd_check_i),
    .fix_data_o(fix_data_o),
    .syndrome_o(syndrome_o),
    .err_n_o   (err_n_o),
    .merr_n_o  (merr_n_o)
);

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] enc_data_i = '0;
    logic [6:0]  enc_check_o;
    logic [31:0] rd_data_i = '0;
    logic [6:0]  rd_check_i = '0;
    logic [31:0] fix_data_o;
    logic [6:0]  syndrome_o;
    logic        err_n_o;
    logic        merr_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [6:0] col [32];

    always #10 clk = ~clk;

    secded_codec u_dut (
        .clk(clk), .rst_n(rst_n),
        .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
        .rd_data_i(rd_data_i), .rd_check_i(rd_check_i),
        .fix_data_o(fix_data_o), .syndrome_o(syndrome_o),
        .err_n_o(err_n_o), .merr_n_o(merr_n_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [6:0] exp_enc(input logic [31:0] d);
        logic [6:0] c = 7'h03;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= col[i];
        return c;
    endfunction

    function automatic logic [6:0] err_sig(input int pos);
        if (pos < 32) return col[pos];
        return 7'(1 << (pos - 32));
    endfunction

    task automatic read_word(input logic [31:0] d, input logic [6:0] c);
        rd_data_i  = d;
        rd_check_i = c;
        step();
    endtask

    task automatic sweep_word(input logic [31:0] d, input bit doubles);
        logic [38:0] w, f;
        logic [6:0]  s;
        w = {exp_enc(d), d};
        read_word(w[31:0], w[38:32]);
        check("R3 syndrome", syndrome_o, 0);
        check("R3 flags", {err_n_o, merr_n_o}, 2'b11);
        check("R3 data", fix_data_o, d);
        for (int a = 0; a < 39; a++) begin
            f = w ^ (39'd1 << a);
            read_word(f[31:0], f[38:32]);
            if (a < 32) begin
                check("R4 flags", {err_n_o, merr_n_o}, 2'b01);
                check("R4 syndrome", syndrome_o, col[a]);
                check("R4 corrected", fix_data_o, d);
            end else begin
                check("R5 flags", {err_n_o, merr_n_o}, 2'b01);
                check("R5 syndrome", syndrome_o, 64'(1 << (a - 32)));
                check("R5 data", fix_data_o, f[31:0]);
            end
        end
        if (doubles) begin
            for (int a = 0; a < 39; a++) begin
                for (int b = a + 1; b < 39; b++) begin
                    f = w ^ (39'd1 << a) ^ (39'd1 << b);
                    s = err_sig(a) ^ err_sig(b);
                    read_word(f[31:0], f[38:32]);
                    check("R6 flags", {err_n_o, merr_n_o}, 2'b00);
                    check("R6 syndrome", syndrome_o, s);
                    check("R6 even nonzero", (syndrome_o != 0) && ($countones(syndrome_o) % 2 == 0), 1);
                end
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [6:0]  c;
        int          ones;
        enc_data_i = 32'hFFFF_FFFF;
        rd_data_i  = 32'h1234_5678;
        rd_check_i = 7'h55;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset check", enc_check_o, 0);
        check("R11 reset data", fix_data_o, 0);
        check("R11 reset syndrome", syndrome_o, 0);
        check("R11 reset flags", {err_n_o, merr_n_o}, 2'b11);
        rst_n = 1'b1;

        // R12: all-zero data encodes to the inversion mask
        enc_data_i = '0;
        step();
        check("R12 zero encode", enc_check_o, 7'h03);

        // R11 latency: output follows input after exactly one edge
        enc_data_i = 32'h1;
        @(posedge clk); #1;
        c = enc_check_o;
        @(negedge clk);
        check("R11 latency", enc_check_o, c);

        // learn columns from unit vectors
        for (int i = 0; i < 32; i++) begin
            enc_data_i = 32'(1) << i;
            step();
            col[i] = enc_check_o ^ 7'h03;
            check("R2 column weight", ($countones(col[i]) == 3) || ($countones(col[i]) == 5), 1);
        end
        for (int i = 0; i < 32; i++)
            for (int j = i + 1; j < 32; j++)
                check("R2 distinct columns", col[i] == col[j], 0);
        for (int r = 0; r < 7; r++) begin
            ones = 0;
            for (int i = 0; i < 32; i++) ones += col[i][r];
            check("R1 row coverage", ones, 16);
        end

        // R1 linearity of the encoder over assorted words
        for (int k = 0; k < 40; k++) begin
            d = $urandom;
            enc_data_i = d;
            step();
            check("R1 encode", enc_check_o, exp_enc(d));
        end

        // R3/R4/R5/R6 sweeps
        sweep_word(32'h0000_0000, 1'b1);
        sweep_word(32'hDEAD_BEEF, 1'b1);
        sweep_word(32'hFFFF_FFFF, 1'b0);
        sweep_word(32'hA5A5_5A5A, 1'b0);

        // R7: weight-7 syndrome matches no column
        d = 32'h0F0F_3C3C;
        read_word(d, exp_enc(d) ^ 7'h7F);
        check("R7 flags", {err_n_o, merr_n_o}, 2'b00);
        check("R7 data unchanged", fix_data_o, d);
        check("R7 syndrome", syndrome_o, 7'h7F);

        // R8 / R9: gross patterns
        read_word('0, '0);
        check("R8 all zeros flags", {err_n_o, merr_n_o}, 2'b00);
        read_word('1, '1);
        check("R9 all ones err", err_n_o, 0);

        // R10: arbitrary check words against arbitrary data
        for (int k = 0; k < 40; k++) begin
            d = $urandom;
            c = 7'($urandom);
            read_word(d, c);
            check("R10 syndrome", syndrome_o, c ^ exp_enc(d));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule